// File: doc/BRIEF.md
# Four-Bank Byte Register File with Pointer Access

This block is the data store of a small controller. It holds four banks of 128 byte offsets each. Every bank starts with a region of special registers and continues with general purpose RAM. A read returns data combinationally for the current address. A write lands on the rising clock edge.

An access reaches its byte in one of two ways:

- **Direct mode.** The 7-bit offset from the instruction is prefixed with two bank bits held in the status register.
- **Pointer mode.** The 8-bit pointer register supplies the offset and one bank bit. A third bit of the status register supplies the upper bank bit.

The status register and the pointer register are shared by all four banks, so the same physical copy answers at its offset in every bank. A single "local" special register exists separately in each bank. The other special offsets are unimplemented.

Top module: `bankfile_top`

## Requirements
- R1: While reset is low, and after it is released, the status and pointer registers are 00h. Each bank's local register is also 00h, so reading offsets 03h, 04h and 0Ah returns 00h.
- R2: In direct mode (accessMode=0) the bank is formed from status bit 6 (upper) and status bit 5 (lower). The values 00, 01, 10 and 11 select banks 0, 1, 2 and 3.
- R3: Offsets 20h to 7Fh are general purpose bytes with separate storage in each bank. A write in one bank leaves the same offset in the other banks unchanged.
- R4: The status register (offset 03h) and the pointer register (offset 04h) are a single copy shared by all banks. A write through any bank is read back through every bank.
- R5: Offset 0Ah is a local special register with one copy per bank. A write reaches only the copy of the selected bank.
- R6: In pointer mode (accessMode=1) the addr input is ignored and status bits 6 and 5 are not used. The bank is {status bit 7, pointer bit 7} and the offset is pointer bits 6..0, which may also select a special register.
- R7: Special offsets below 20h other than 03h, 04h and 0Ah read as 00h, and writes to them are dropped.
- R8: A write takes effect at the rising clock edge. Before that edge, a read of the same location returns the old value. A write to the status register changes the bank used from the next cycle on.
- R9: With wrEn low, no location changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| accessMode | input | 1 | 0 = direct offset with status bank bits, 1 = through the pointer register |
| addr | input | 7 | Offset within the bank in direct mode |
| wrEn | input | 1 | Write strobe for the selected location |
| wrData | input | 8 | Byte to be written |
| rdData | output | 8 | Byte at the selected location, combinational |

## Verification
The read path and the write path share a cycle whenever wrEn is high. Two cases matter most:

- **Write and read of the same general purpose byte.** The bench drives the write and samples rdData twice. A sample just before the edge must show the old byte, and a sample just after it must show the new one.
- **Write to the status register.** In the same cycle, the location being read still resolves through the old bank bits. The next read at an unchanged offset must come from the newly selected bank.

The expected bytes follow from the bank and offset arithmetic stated in the requirements.

// File: rtl/bankfile_pkg.sv
package bankfile_pkg;
  localparam int DATA_W    = 8;
  localparam int OFS_W     = 7;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int BANK_SPAN = 1 << OFS_W;

  // Decoded access handed from control to datapath
  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  offset;
    logic              selStatus;
    logic              selPtr;
    logic              selLocal;
    logic              selGpr;
    logic              wrStrobe;
  } fileStrobeT;
endpackage

// File: rtl/bankfile_ctrl.sv
module bankfile_ctrl
  import bankfile_pkg::*;
#(
  parameter int SFR_LIMIT = 32,
  parameter int STAT_OFS  = 3,
  parameter int PTR_OFS   = 4,
  parameter int LOCAL_OFS = 10
) (
  input  logic              accessMode,
  input  logic [OFS_W-1:0]  addr,
  input  logic              wrEn,
  input  logic [2:0]        bankBits,   // {hiIndirect, hiDirect, loDirect}
  input  logic [DATA_W-1:0] ptrQ,
  output fileStrobeT        strb
);
  logic [BANK_W-1:0] directBank;
  logic [BANK_W-1:0] pointerBank;
  logic [BANK_W-1:0] effBank;
  logic [OFS_W-1:0]  effOfs;
  logic              anyHit;

  assign directBank  = bankBits[1:0];
  assign pointerBank = {bankBits[2], ptrQ[DATA_W-1]};

  always_comb begin
    effBank = accessMode ? pointerBank : directBank;
    effOfs  = accessMode ? ptrQ[OFS_W-1:0] : addr;

    strb           = '0;
    strb.bank      = effBank;
    strb.offset    = effOfs;
    strb.selStatus = (effOfs == OFS_W'(STAT_OFS));
    strb.selPtr    = (effOfs == OFS_W'(PTR_OFS));
    strb.selLocal  = (effOfs == OFS_W'(LOCAL_OFS));
    strb.selGpr    = (effOfs >= OFS_W'(SFR_LIMIT));
    anyHit         = strb.selStatus | strb.selPtr | strb.selLocal | strb.selGpr;
    strb.wrStrobe  = wrEn & anyHit;
  end
endmodule

// File: rtl/bankfile_dpath.sv
module bankfile_dpath
  import bankfile_pkg::*;
#(
  parameter int SFR_LIMIT = 32,
  parameter int RP0_BIT   = 5,
  parameter int RP1_BIT   = 6,
  parameter int IRP_BIT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  fileStrobeT        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        bankBits,
  output logic [DATA_W-1:0] ptrQ
);
  localparam int GPR_DEPTH = BANK_SPAN - SFR_LIMIT;

  logic [DATA_W-1:0] statusQ;
  logic [OFS_W-1:0]  gprOfs;
  logic [DATA_W-1:0] localRd [NUM_BANKS];
  logic [DATA_W-1:0] gprRd   [NUM_BANKS];

  assign gprOfs   = strb.offset - OFS_W'(SFR_LIMIT);
  assign bankBits = {statusQ[IRP_BIT], statusQ[RP1_BIT], statusQ[RP0_BIT]};

  // Shared registers: one physical copy answers in every bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      ptrQ    <= '0;
    end else if (strb.wrStrobe) begin
      if (strb.selStatus) statusQ <= wrData;
      if (strb.selPtr)    ptrQ    <= wrData;
    end
  end

  // Per-bank storage: local special register and general purpose RAM
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] localQ;
    logic [DATA_W-1:0] gprMem [GPR_DEPTH];
    logic              bankHit;

    assign bankHit = (strb.bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        localQ <= '0;
      else if (strb.wrStrobe && strb.selLocal && bankHit)
        localQ <= wrData;
    end

    always_ff @(posedge clk) begin
      if (strb.wrStrobe && strb.selGpr && bankHit)
        gprMem[gprOfs] <= wrData;
    end

    assign localRd[b] = localQ;
    assign gprRd[b]   = gprMem[gprOfs];
  end

  always_comb begin
    rdData = '0;
    if (strb.selGpr)         rdData = gprRd[strb.bank];
    else if (strb.selStatus) rdData = statusQ;
    else if (strb.selPtr)    rdData = ptrQ;
    else if (strb.selLocal)  rdData = localRd[strb.bank];
  end
endmodule

// File: rtl/bankfile_top.sv
module bankfile_top
  import bankfile_pkg::*;
#(
  parameter int SFR_LIMIT = 32,
  parameter int STAT_OFS  = 3,
  parameter int PTR_OFS   = 4,
  parameter int LOCAL_OFS = 10,
  parameter int RP0_BIT   = 5,
  parameter int RP1_BIT   = 6,
  parameter int IRP_BIT   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accessMode,
  input  logic [6:0]  addr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData
);
  fileStrobeT        strb;
  logic [2:0]        bankBits;
  logic [DATA_W-1:0] ptrQ;

  bankfile_ctrl #(
    .SFR_LIMIT(SFR_LIMIT), .STAT_OFS(STAT_OFS),
    .PTR_OFS(PTR_OFS), .LOCAL_OFS(LOCAL_OFS)
  ) u_ctrl (
    .accessMode(accessMode), .addr(addr), .wrEn(wrEn),
    .bankBits(bankBits), .ptrQ(ptrQ), .strb(strb)
  );

  bankfile_dpath #(
    .SFR_LIMIT(SFR_LIMIT), .RP0_BIT(RP0_BIT),
    .RP1_BIT(RP1_BIT), .IRP_BIT(IRP_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .bankBits(bankBits), .ptrQ(ptrQ)
  );
endmodule

// File: rtl/bankfile_check.sv
module bankfile_check #(
  parameter int SFR_LIMIT = 32,
  parameter int STAT_OFS  = 3,
  parameter int PTR_OFS   = 4,
  parameter int LOCAL_OFS = 10,
  parameter int RP0_BIT   = 5,
  parameter int RP1_BIT   = 6,
  parameter int IRP_BIT   = 7
) (
  input logic       clk,
  input logic       rstN,
  input logic       accessMode,
  input logic [6:0] addr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [2:0] bankBits,
  input logic [7:0] ptrQ
);
  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  logic unimplDirect;
  assign unimplDirect = !accessMode && (addr < 7'(SFR_LIMIT)) &&
                        (addr != 7'(STAT_OFS)) && (addr != 7'(PTR_OFS)) &&
                        (addr != 7'(LOCAL_OFS));

  // R1: first cycle after reset release sees cleared bank bits and pointer
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(rstN) |-> (bankBits == 3'b000) && (ptrQ == 8'h00));

  // R4: status read through any bank returns the shared bank bits
  assert_status_mirror_R4: assert property (@(posedge clk) disable iff (!rstN)
    !accessMode && addr == 7'(STAT_OFS) |->
      rdData[RP1_BIT] == bankBits[1] && rdData[RP0_BIT] == bankBits[0] &&
      rdData[IRP_BIT] == bankBits[2]);

  // R6: pointer aimed at the status offset returns the status register
  assert_ptr_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    accessMode && ptrQ[6:0] == 7'(STAT_OFS) |->
      rdData[IRP_BIT] == bankBits[2] && rdData[RP1_BIT] == bankBits[1] &&
      rdData[RP0_BIT] == bankBits[0]);

  // R7: unimplemented special offsets read as zero
  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    unimplDirect |-> rdData == 8'h00);

  // R8: a direct RAM write is visible at the same offset one cycle later
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(rstN && wrEn && !accessMode && addr >= 7'(SFR_LIMIT)) &&
    !accessMode && $stable(addr) |-> rdData == $past(wrData));

  // R9: without a write the selected byte holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(rstN) && !$past(wrEn) && $stable(addr) &&
    $stable(accessMode) |-> $stable(rdData));
endmodule

bind bankfile_top bankfile_check #(
  .SFR_LIMIT(SFR_LIMIT), .STAT_OFS(STAT_OFS), .PTR_OFS(PTR_OFS),
  .LOCAL_OFS(LOCAL_OFS), .RP0_BIT(RP0_BIT), .RP1_BIT(RP1_BIT), .IRP_BIT(IRP_BIT)
) u_check (
  .clk(clk), .rstN(rstN), .accessMode(accessMode), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .bankBits(bankBits), .ptrQ(ptrQ)
);

// File: tb/bankfile_top_test.sv
module bankfile_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accessMode = 1'b0;
  logic [6:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bankfile_top uut (
    .clk(clk), .rstN(rstN), .accessMode(accessMode), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  typedef struct packed {
    logic       mode;
    logic [6:0] ofs;
    logic       we;
    logic [7:0] data;
    logic       chk;
    logic [7:0] exp;
    logic [3:0] req;
  } vecT;

  localparam int NV = 40;
  localparam vecT VECS [NV] = '{
    '{1'b0, 7'h03, 1'b1, 8'h00, 1'b0, 8'h00, 4'd2},  // R2 bank 0
    '{1'b0, 7'h30, 1'b1, 8'hA0, 1'b0, 8'h00, 4'd3},  // R3
    '{1'b0, 7'h03, 1'b1, 8'h20, 1'b0, 8'h00, 4'd2},  // R2 bank 1
    '{1'b0, 7'h30, 1'b1, 8'hA1, 1'b0, 8'h00, 4'd3},
    '{1'b0, 7'h03, 1'b1, 8'h40, 1'b0, 8'h00, 4'd2},  // bank 2
    '{1'b0, 7'h30, 1'b1, 8'hA2, 1'b0, 8'h00, 4'd3},
    '{1'b0, 7'h03, 1'b1, 8'h60, 1'b0, 8'h00, 4'd2},  // bank 3
    '{1'b0, 7'h30, 1'b1, 8'hA3, 1'b0, 8'h00, 4'd3},
    '{1'b0, 7'h03, 1'b0, 8'h00, 1'b1, 8'h60, 4'd4},  // R4 status via bank 3
    '{1'b0, 7'h30, 1'b0, 8'h00, 1'b1, 8'hA3, 4'd2},
    '{1'b0, 7'h03, 1'b1, 8'h00, 1'b0, 8'h00, 4'd2},
    '{1'b0, 7'h30, 1'b0, 8'h00, 1'b1, 8'hA0, 4'd3},  // R3 bank 0 intact
    '{1'b0, 7'h03, 1'b1, 8'h20, 1'b0, 8'h00, 4'd2},
    '{1'b0, 7'h30, 1'b0, 8'h00, 1'b1, 8'hA1, 4'd3},
    '{1'b0, 7'h03, 1'b1, 8'h40, 1'b0, 8'h00, 4'd2},
    '{1'b0, 7'h30, 1'b0, 8'h00, 1'b1, 8'hA2, 4'd3},
    '{1'b0, 7'h0A, 1'b1, 8'h52, 1'b0, 8'h00, 4'd5},  // R5 local in bank 2
    '{1'b0, 7'h03, 1'b1, 8'h00, 1'b0, 8'h00, 4'd2},
    '{1'b0, 7'h0A, 1'b1, 8'h50, 1'b0, 8'h00, 4'd5},  // local in bank 0
    '{1'b0, 7'h0A, 1'b0, 8'h00, 1'b1, 8'h50, 4'd5},
    '{1'b0, 7'h03, 1'b1, 8'h40, 1'b0, 8'h00, 4'd2},
    '{1'b0, 7'h0A, 1'b0, 8'h00, 1'b1, 8'h52, 4'd5},
    '{1'b0, 7'h04, 1'b1, 8'hB0, 1'b0, 8'h00, 4'd4},  // R4 pointer via bank 2
    '{1'b0, 7'h03, 1'b1, 8'h20, 1'b0, 8'h00, 4'd4},
    '{1'b0, 7'h04, 1'b0, 8'h00, 1'b1, 8'hB0, 4'd4},  // pointer via bank 1
    '{1'b1, 7'h0A, 1'b0, 8'h00, 1'b1, 8'hA1, 4'd6},  // R6 bank {0,1}
    '{1'b0, 7'h03, 1'b1, 8'h80, 1'b0, 8'h00, 4'd6},
    '{1'b1, 7'h0A, 1'b0, 8'h00, 1'b1, 8'hA3, 4'd6},  // bank {1,1}
    '{1'b0, 7'h04, 1'b1, 8'h30, 1'b0, 8'h00, 4'd6},
    '{1'b1, 7'h04, 1'b0, 8'h00, 1'b1, 8'hA2, 4'd6},  // bank {1,0}, bank bits 00
    '{1'b1, 7'h7F, 1'b1, 8'h77, 1'b0, 8'h00, 4'd6},  // pointer write to bank 2
    '{1'b0, 7'h03, 1'b1, 8'h40, 1'b0, 8'h00, 4'd6},
    '{1'b0, 7'h30, 1'b0, 8'h00, 1'b1, 8'h77, 4'd6},
    '{1'b0, 7'h04, 1'b1, 8'h03, 1'b0, 8'h00, 4'd6},
    '{1'b1, 7'h30, 1'b0, 8'h00, 1'b1, 8'h40, 4'd6},  // pointer reaches status
    '{1'b0, 7'h05, 1'b1, 8'hFF, 1'b0, 8'h00, 4'd7},  // R7
    '{1'b0, 7'h05, 1'b0, 8'h00, 1'b1, 8'h00, 4'd7},
    '{1'b0, 7'h1F, 1'b0, 8'h00, 1'b1, 8'h00, 4'd7},
    '{1'b0, 7'h30, 1'b0, 8'h11, 1'b1, 8'h77, 4'd9},  // R9 strobe low
    '{1'b0, 7'h30, 1'b0, 8'h00, 1'b1, 8'h77, 4'd9}
  };

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%02h expected %02h", tag, rdData, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [6:0] o, input logic w,
                       input logic [7:0] d);
    accessMode = m; addr = o; wrEn = w; wrData = d;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1'b0, 7'h03, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    #1 check(8'h00, "R1 status in reset");
    rstN = 1'b1;
    @(negedge clk);
    #1 check(8'h00, "R1 status after reset");
    drive(1'b0, 7'h04, 1'b0, 8'h00);
    #1 check(8'h00, "R1 pointer after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].mode, VECS[i].ofs, VECS[i].we, VECS[i].data);
      #1;
      if (VECS[i].chk) check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R8 same-cycle write and read of one RAM byte (bank 2, 30h holds 77h)
    @(negedge clk);
    drive(1'b0, 7'h30, 1'b1, 8'h55);
    #1 check(8'h77, "R8 old byte before edge");
    @(posedge clk);
    #1 check(8'h55, "R8 new byte after edge");

    // R8 status write switches bank only after the edge
    @(negedge clk);
    drive(1'b0, 7'h03, 1'b1, 8'h60);
    #1 check(8'h40, "R8 old status before edge");
    @(posedge clk);
    #1 check(8'h60, "R8 new status after edge");
    @(negedge clk);
    drive(1'b0, 7'h30, 1'b0, 8'h00);
    #1 check(8'hA3, "R2 bank 3 after status write");

    // R1 reset in mid-run clears shared and local registers
    @(negedge clk);
    drive(1'b0, 7'h0A, 1'b0, 8'h00);
    #1 check(8'h00, "R5 local in bank 3 unwritten");
    rstN = 1'b0;
    #1 drive(1'b0, 7'h03, 1'b0, 8'h00);
    #1 check(8'h00, "R1 status cleared");
    drive(1'b0, 7'h04, 1'b0, 8'h00);
    #1 check(8'h00, "R1 pointer cleared");
    drive(1'b0, 7'h0A, 1'b0, 8'h00);
    #1 check(8'h00, "R1 bank 0 local cleared");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule